// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block works out operand addresses for a processor's load and store path. It holds eight sets of registers. Each set has an index pointer, a length and a base. A separate file of eight signed modify values is chosen by its own select. An access request names a pointer and a modify register, and chooses one of two modes:

- **Pre-modify:** the emitted address is pointer plus modify, and the pointer keeps its value.
- **Post-modify:** the emitted address is the pointer, and the pointer moves by the modify.

When the pointer's length is nonzero, the moved value is folded back into the window that starts at the base and is length words long. A control bit can emit the address with its bits in reverse order, for FFT-style traversal. None of this costs extra cycles. A second full copy of every register can be swapped in with a single pulse, so interrupt code gets its own pointers without any saving or restoring.

Requests use a valid/ready handshake, and the address leaves through a one-entry valid/ready output register. The request side is ready whenever the output register is empty or is being drained in the same cycle. While the output is stalled, the address it holds does not change, and a request that is offered but not accepted leaves every register untouched.

Software reaches the registers through a plain write port and a combinational read port. Both address a register by a 2-bit file code and a pointer select.

Top module: `agu_top`

## Requirements
- R1: After reset, every register in both copies reads 0, `out_valid` is low, `req_ready` is high, and the primary copy is active.
- R2: There are eight independent register sets. The file code selects the file: 0 = index, 1 = modify, 2 = length, 3 = base. A write to one entry changes only that entry, and the read port returns the addressed entry of the active copy in the same cycle.
- R3: Post-modify (`req_pre`=0): the emitted address is the current index, and the index then becomes index plus modify.
- R4: Pre-modify (`req_pre`=1): the emitted address is index plus modify (folded as in R6), and the index keeps its value.
- R5: Modify values are two's complement. A negative modify moves the pointer downward.
- R6: With a nonzero length L and base B, a moved pointer at or above B+L has L subtracted, and one below B has L added. This holds for any modify whose magnitude does not exceed L.
- R7: With a length of 0, the pointer moves linearly, modulo 2^AW.
- R8: With `rev_en` high on the accepted request, the emitted address is the unreversed address with bit i moved to bit AW-1-i. The stored pointer is never reversed.
- R9: `req_ready` equals `!out_valid || out_ready`. A request is accepted only when `req_valid` and `req_ready` are both high, and its address appears on `out_addr` with `out_valid` one clock later. While `out_valid` is high and `out_ready` is low, `out_addr` holds steady, and a request that is not accepted changes no register.
- R10: If a register write to an index and a post-modify access to the same pointer happen in the same cycle, the written value is stored. The emitted address is still the old index.
- R11: A one-cycle `bank_swap` pulse switches both the register port and the access path to the other copy. The contents of the copy that is set aside are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_swap | input | 1 | Pulse that exchanges the primary and alternate register copies |
| wr_en | input | 1 | Register write strobe |
| wr_file | input | 2 | File code of the write (0 index, 1 modify, 2 length, 3 base) |
| wr_sel | input | $clog2(NPTR) | Entry written |
| wr_data | input | AW | Data written |
| rd_file | input | 2 | File code of the read |
| rd_sel | input | $clog2(NPTR) | Entry read |
| rd_data | output | AW | Combinational read data |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Access request can be taken |
| req_ptr | input | $clog2(NPTR) | Pointer set used (index, length, base) |
| req_msel | input | $clog2(NPTR) | Modify register used |
| req_pre | input | 1 | 1 = pre-modify, 0 = post-modify |
| rev_en | input | 1 | Emit the address bit-reversed |
| out_valid | output | 1 | Address register holds a result |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | AW | Generated address |

## Verification
The bench builds the block with AW = 16 and the default eight pointer sets. Sixteen bits keep the expected addresses short enough to state by hand. The narrow width also lets a linear update wrap past 0xFFFF, and makes full-width bit reversal visible as single set bits jumping to the top of the word. The circular tests land exactly on base plus length and fall below base, so both fold directions and the exclusive upper bound are covered. The swap test fills the alternate copy through the same ports to show that the two copies are independent.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    FILE_IDX  = 2'd0,
    FILE_MOD  = 2'd1,
    FILE_LEN  = 2'd2,
    FILE_BASE = 2'd3
  } agu_file_e;

endpackage

// File: rtl/agu_regbank.sv
module agu_regbank
  import agu_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NPTR = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     swap,
  input  logic                     wr_en,
  input  logic [1:0]               wr_file,
  input  logic [$clog2(NPTR)-1:0]  wr_sel,
  input  logic [AW-1:0]            wr_data,
  input  logic [1:0]               rd_file,
  input  logic [$clog2(NPTR)-1:0]  rd_sel,
  output logic [AW-1:0]            rd_data,
  input  logic [$clog2(NPTR)-1:0]  acc_ptr,
  input  logic [$clog2(NPTR)-1:0]  acc_msel,
  output logic [AW-1:0]            acc_idx,
  output logic [AW-1:0]            acc_mod,
  output logic [AW-1:0]            acc_len,
  output logic [AW-1:0]            acc_base,
  input  logic                     upd_en,
  input  logic [$clog2(NPTR)-1:0]  upd_ptr,
  input  logic [AW-1:0]            upd_val
);

  localparam int NCOPY = 2;

  logic [AW-1:0] idx_q  [NCOPY][NPTR];
  logic [AW-1:0] mod_q  [NCOPY][NPTR];
  logic [AW-1:0] len_q  [NCOPY][NPTR];
  logic [AW-1:0] base_q [NCOPY][NPTR];
  logic          act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      for (int b = 0; b < NCOPY; b++) begin
        for (int k = 0; k < NPTR; k++) begin
          idx_q[b][k]  <= '0;
          mod_q[b][k]  <= '0;
          len_q[b][k]  <= '0;
          base_q[b][k] <= '0;
        end
      end
    end else begin
      if (swap) act_q <= ~act_q;
      // pointer update first so that a same-cycle register write overrides it
      if (upd_en) idx_q[act_q][upd_ptr] <= upd_val;
      if (wr_en) begin
        unique case (agu_file_e'(wr_file))
          FILE_IDX:  idx_q[act_q][wr_sel]  <= wr_data;
          FILE_MOD:  mod_q[act_q][wr_sel]  <= wr_data;
          FILE_LEN:  len_q[act_q][wr_sel]  <= wr_data;
          FILE_BASE: base_q[act_q][wr_sel] <= wr_data;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (agu_file_e'(rd_file))
      FILE_IDX:  rd_data = idx_q[act_q][rd_sel];
      FILE_MOD:  rd_data = mod_q[act_q][rd_sel];
      FILE_LEN:  rd_data = len_q[act_q][rd_sel];
      FILE_BASE: rd_data = base_q[act_q][rd_sel];
      default:   rd_data = '0;
    endcase
  end

  assign acc_idx  = idx_q[act_q][acc_ptr];
  assign acc_mod  = mod_q[act_q][acc_msel];
  assign acc_len  = len_q[act_q][acc_ptr];
  assign acc_base = base_q[act_q][acc_ptr];

  // R10
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_file == FILE_IDX && upd_en && upd_ptr == wr_sel && !swap)
      |=> (idx_q[act_q][$past(wr_sel)] == $past(wr_data)));

endmodule

// File: rtl/agu_calc.sv
module agu_calc #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] mod,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] base,
  input  logic          pre,
  input  logic          rev,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] nxt
);

  logic          neg;
  logic [AW-1:0] mag, lin, circ, pick, rv;
  logic [AW:0]   lim, up, floor_ext;

  always_comb begin
    neg       = mod[AW-1];
    mag       = neg ? (~mod + 1'b1) : mod;
    lin       = ptr + mod;
    lim       = {1'b0, base} + {1'b0, len};
    up        = {1'b0, ptr} + {1'b0, mod};
    floor_ext = {1'b0, base} + {1'b0, mag};
    if (len == '0)  circ = lin;
    else if (!neg)  circ = (up >= lim) ? (lin - len) : lin;
    else            circ = ({1'b0, ptr} < floor_ext) ? (lin + len) : lin;
    nxt  = circ;
    pick = pre ? circ : ptr;
  end

  for (genvar i = 0; i < AW; i++) begin : g_rev
    assign rv[i] = pick[AW-1-i];
  end

  assign addr = rev ? rv : pick;

endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int AW   = 32,
  parameter int NPTR = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bank_swap,
  input  logic                     wr_en,
  input  logic [1:0]               wr_file,
  input  logic [$clog2(NPTR)-1:0]  wr_sel,
  input  logic [AW-1:0]            wr_data,
  input  logic [1:0]               rd_file,
  input  logic [$clog2(NPTR)-1:0]  rd_sel,
  output logic [AW-1:0]            rd_data,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [$clog2(NPTR)-1:0]  req_ptr,
  input  logic [$clog2(NPTR)-1:0]  req_msel,
  input  logic                     req_pre,
  input  logic                     rev_en,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [AW-1:0]            out_addr
);

  logic          accept, upd_en;
  logic [AW-1:0] acc_idx, acc_mod, acc_len, acc_base;
  logic [AW-1:0] calc_addr, calc_nxt;
  logic          out_valid_q;
  logic [AW-1:0] out_addr_q;

  assign req_ready = !out_valid_q || out_ready;
  assign accept    = req_valid && req_ready;
  assign upd_en    = accept && !req_pre;

  agu_regbank #(.AW(AW), .NPTR(NPTR)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap     (bank_swap),
    .wr_en    (wr_en),
    .wr_file  (wr_file),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_file  (rd_file),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .acc_ptr  (req_ptr),
    .acc_msel (req_msel),
    .acc_idx  (acc_idx),
    .acc_mod  (acc_mod),
    .acc_len  (acc_len),
    .acc_base (acc_base),
    .upd_en   (upd_en),
    .upd_ptr  (req_ptr),
    .upd_val  (calc_nxt)
  );

  agu_calc #(.AW(AW)) u_calc (
    .ptr  (acc_idx),
    .mod  (acc_mod),
    .len  (acc_len),
    .base (acc_base),
    .pre  (req_pre),
    .rev  (rev_en),
    .addr (calc_addr),
    .nxt  (calc_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_addr_q  <= '0;
    end else if (req_ready) begin
      out_valid_q <= req_valid;
      if (accept) out_addr_q <= calc_addr;
    end
  end

  assign out_valid = out_valid_q;
  assign out_addr  = out_addr_q;

  // checker-side view of the circular window
  logic [AW:0]   win_end;
  logic [AW-1:0] mod_mag;
  logic          in_win, nxt_in_win;
  assign win_end    = {1'b0, acc_base} + {1'b0, acc_len};
  assign mod_mag    = acc_mod[AW-1] ? (~acc_mod + 1'b1) : acc_mod;
  assign in_win     = (acc_idx >= acc_base) && ({1'b0, acc_idx} < win_end);
  assign nxt_in_win = (calc_nxt >= acc_base) && ({1'b0, calc_nxt} < win_end);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  // R6
  wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_len != '0 && in_win && mod_mag <= acc_len) |-> nxt_in_win);

  // R7
  linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_len == '0) |-> (calc_nxt == acc_idx + acc_mod));

endmodule

// File: tb/agu_top_bench.sv
`timescale 1ns/1ps
module agu_top_bench;

  localparam int AW   = 16;
  localparam int NPTR = 8;
  localparam int SW   = $clog2(NPTR);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bank_swap = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_file = '0;
  logic [SW-1:0] wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic [1:0]    rd_file = '0;
  logic [SW-1:0] rd_sel = '0;
  logic [AW-1:0] rd_data;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [SW-1:0] req_ptr = '0;
  logic [SW-1:0] req_msel = '0;
  logic          req_pre = 1'b0;
  logic          rev_en = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  agu_top #(.AW(AW), .NPTR(NPTR)) u_agu_top (
    .clk(clk), .rst_n(rst_n), .bank_swap(bank_swap),
    .wr_en(wr_en), .wr_file(wr_file), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_file(rd_file), .rd_sel(rd_sel), .rd_data(rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_ptr(req_ptr),
    .req_msel(req_msel), .req_pre(req_pre), .rev_en(rev_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] f, input int sel, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_file = f; wr_sel = SW'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] f, input int sel, output logic [AW-1:0] v);
    rd_file = f; rd_sel = SW'(sel);
    #1;
    v = rd_data;
  endtask

  task automatic acc(input int p, input int m, input logic pre, input logic rev,
                     input logic [AW-1:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_ptr = SW'(p); req_msel = SW'(m); req_pre = pre; rev_en = rev;
    @(negedge clk);
    req_valid = 1'b0; rev_en = 1'b0;
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " addr"}, 32'(out_addr), 32'(exp));
  endtask

  task automatic t_reset;
    logic [AW-1:0] v;
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 req_ready", 32'(req_ready), 32'd1);
    rd(2'd0, 0, v); chk("R1 idx0", 32'(v), 32'd0);
    rd(2'd3, 7, v); chk("R1 base7", 32'(v), 32'd0);
  endtask

  task automatic t_independent;
    logic [AW-1:0] v;
    for (int k = 0; k < NPTR; k++) wr(2'd0, k, AW'(16'h1000 + k * 16'h11));
    wr(2'd1, 1, 16'h0007);
    for (int k = 0; k < NPTR; k++) begin
      rd(2'd0, k, v);
      chk("R2 idx entry", 32'(v), 32'(16'h1000 + k * 16'h11));
    end
    rd(2'd1, 1, v); chk("R2 mod1", 32'(v), 32'h7);
  endtask

  task automatic t_post_pre_neg;
    logic [AW-1:0] v;
    wr(2'd0, 3, 16'd100);
    wr(2'd1, 2, 16'd5);
    acc(3, 2, 1'b0, 1'b0, 16'd100, "R3 post");
    rd(2'd0, 3, v); chk("R3 idx moved", 32'(v), 32'd105);
    acc(3, 2, 1'b1, 1'b0, 16'd110, "R4 pre");
    rd(2'd0, 3, v); chk("R4 idx kept", 32'(v), 32'd105);
    wr(2'd1, 4, 16'hFFFD);
    acc(3, 4, 1'b0, 1'b0, 16'd105, "R5 neg");
    rd(2'd0, 3, v); chk("R5 idx down", 32'(v), 32'd102);
  endtask

  task automatic t_linear;
    logic [AW-1:0] v;
    wr(2'd0, 1, 16'hFFFE);
    acc(1, 2, 1'b0, 1'b0, 16'hFFFE, "R7 linear");
    rd(2'd0, 1, v); chk("R7 idx wraps 2^AW", 32'(v), 32'h3);
  endtask

  task automatic t_circ;
    logic [AW-1:0] v;
    wr(2'd3, 4, 16'h0200);
    wr(2'd2, 4, 16'd10);
    wr(2'd0, 4, 16'h0208);
    wr(2'd1, 0, 16'd4);
    wr(2'd1, 5, 16'hFFFC);
    acc(4, 0, 1'b0, 1'b0, 16'h0208, "R6 up");
    rd(2'd0, 4, v); chk("R6 fold down", 32'(v), 32'h0202);
    acc(4, 5, 1'b0, 1'b0, 16'h0202, "R6 dn");
    rd(2'd0, 4, v); chk("R6 fold up", 32'(v), 32'h0208);
    acc(4, 0, 1'b1, 1'b0, 16'h0202, "R6 pre fold");
    rd(2'd0, 4, v); chk("R6 pre keeps idx", 32'(v), 32'h0208);
    wr(2'd0, 4, 16'h0206);
    acc(4, 0, 1'b0, 1'b0, 16'h0206, "R6 edge");
    rd(2'd0, 4, v); chk("R6 end bound exclusive", 32'(v), 32'h0200);
  endtask

  task automatic t_bitrev;
    logic [AW-1:0] v;
    wr(2'd0, 5, 16'h0006);
    acc(5, 7, 1'b0, 1'b1, 16'h6000, "R8 rev 6");
    wr(2'd1, 6, 16'd1);
    wr(2'd0, 5, 16'h0001);
    acc(5, 6, 1'b0, 1'b1, 16'h8000, "R8 rev 1");
    rd(2'd0, 5, v); chk("R8 idx not reversed", 32'(v), 32'h2);
    acc(5, 6, 1'b1, 1'b1, 16'hC000, "R8 rev pre 3");
  endtask

  task automatic t_backpressure;
    logic [AW-1:0] v;
    @(negedge clk);
    out_ready = 1'b0;
    req_valid = 1'b1; req_ptr = 3'd3; req_msel = 3'd2; req_pre = 1'b0; rev_en = 1'b0;
    @(negedge clk);
    chk("R9 first valid", 32'(out_valid), 32'd1);
    chk("R9 first addr", 32'(out_addr), 32'd102);
    chk("R9 ready low", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk("R9 held addr", 32'(out_addr), 32'd102);
    rd(2'd0, 3, v); chk("R9 stalled req no effect", 32'(v), 32'd107);
    out_ready = 1'b1;
    #1;
    chk("R9 ready follows out_ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second addr", 32'(out_addr), 32'd107);
    rd(2'd0, 3, v); chk("R9 idx after two", 32'(v), 32'd112);
    @(negedge clk);
    chk("R9 drained", 32'(out_valid), 32'd0);
  endtask

  task automatic t_prio;
    logic [AW-1:0] v;
    @(negedge clk);
    wr_en = 1'b1; wr_file = 2'd0; wr_sel = 3'd3; wr_data = 16'h0050;
    req_valid = 1'b1; req_ptr = 3'd3; req_msel = 3'd2; req_pre = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R10 addr old idx", 32'(out_addr), 32'd112);
    rd(2'd0, 3, v); chk("R10 write wins", 32'(v), 32'h50);
  endtask

  task automatic t_swap;
    logic [AW-1:0] v;
    @(negedge clk); bank_swap = 1'b1;
    @(negedge clk); bank_swap = 1'b0;
    rd(2'd0, 3, v); chk("R11 alt idx3 empty", 32'(v), 32'd0);
    wr(2'd0, 3, 16'h0077);
    wr(2'd1, 2, 16'd1);
    acc(3, 2, 1'b0, 1'b0, 16'h0077, "R11 alt access");
    rd(2'd0, 3, v); chk("R11 alt idx moved", 32'(v), 32'h78);
    @(negedge clk); bank_swap = 1'b1;
    @(negedge clk); bank_swap = 1'b0;
    rd(2'd0, 3, v); chk("R11 primary idx3 kept", 32'(v), 32'h50);
    rd(2'd1, 2, v); chk("R11 primary mod2 kept", 32'(v), 32'd5);
  endtask

  initial begin : watchdog
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_independent();
    t_post_pre_neg();
    t_linear();
    t_circ();
    t_bitrev();
    t_backpressure();
    t_prio();
    t_swap();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule